// File: doc/BRIEF.md
# Multi-Bank Oscillator Tuning Controller

This block sits between a frequency-locking loop and the capacitor banks of a digitally controlled oscillator. It walks through a fixed locking order. First it adjusts a large-step binary bank. Next it adjusts a medium-step binary bank. Last it adjusts a bank of identical unit cells, which is driven by a thermometer code so that each extra step always moves the frequency the same way. While tracking, a first-order sigma-delta modulator spreads a 5-bit fractional word over a few extra unit cells. These cells are updated on a separate, faster enable.

The loop supplies a signed error on each update strobe. The error is added to the word of the bank that is currently active, and that word saturates at its limits. A step pulse finishes the current phase. It freezes that bank's word and starts the next finer bank from mid-scale. A start pulse begins the whole sequence again from the coarse phase.

Top module: `dco_tune_ctrl`

## Requirements
- R1: After reset, phase_o is 0 (idle), coarse_o and acq_o are 128, track_o has 32 cells on, and dith_o is 0.
- R2: A start_i pulse in any phase sets phase_o to 1 (coarse) and reloads coarse_o to 128 at the same clock edge. Phase codes: 0 idle, 1 coarse, 2 acquisition, 3 tracking.
- R3: step_i moves phase 1 to phase 2 and reloads acq_o to 128. It moves phase 2 to phase 3 and reloads the tracking count to 32. It is ignored in phases 0 and 3, and start_i takes priority over it.
- R4: upd_i adds the signed err_i (two's complement) to the word of the active bank only. In idle it changes nothing.
- R5: A bank that is not active keeps its word unchanged.
- R6: coarse_o and acq_o saturate at 0 and 255 and never wrap.
- R7: The tracking count saturates at 0 and 64 and never wraps.
- R8: For a tracking count N, track_o has exactly bits [N-1:0] set and all other bits clear.
- R9: In phase 3, each fast_en_i edge loads dith_o with (c>>2) plus a carry, where c = min(frac_i, 28). The carry comes from a 2-bit accumulator of c[1:0]. dith_o is therefore always c>>2 or c>>2 + 1, and any 4 consecutive enabled updates at a constant frac_i sum to exactly c.
- R10: Outside phase 3, dith_o is held at 0 and the accumulator is cleared, so dithering starts from an empty accumulator when tracking begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart the locking sequence at the coarse phase |
| step_i | input | 1 | Finish the current phase and move to the next finer bank |
| upd_i | input | 1 | Apply err_i to the active bank |
| err_i | input | 6 | Signed tuning error |
| fast_en_i | input | 1 | Update enable for the sigma-delta dither |
| frac_i | input | 5 | Fractional tracking word |
| phase_o | output | 2 | Current locking phase |
| coarse_o | output | 8 | Coarse bank binary word |
| acq_o | output | 8 | Acquisition bank binary word |
| track_o | output | 64 | Tracking bank thermometer code |
| dith_o | output | 3 | Dither level for the extra unit cells |

## Verification
Several properties are checked on every cycle. The thermometer output must be contiguous, with a population equal to the tracking count. A bank may only change while it is active or being reloaded. Tracking and acquisition may only be entered from the phase just before them. Each bank must hold at its limit when pushed further, and each dither level must lie within one step of the clipped input. What the directed scenarios alone can show is the long-run behaviour: the exact saturated values reached after a run of updates, the mid-scale reloads across a full sequence and a restart, and the exact sum of the dither output over windows for each fractional input, including inputs above the clip point.

// File: rtl/dco_tune_pkg.sv
`timescale 1ns/1ps
package dco_tune_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COARSE = 2'd1,
    PH_ACQ    = 2'd2,
    PH_TRACK  = 2'd3
  } phase_e;
endpackage

// File: rtl/dco_tune_seq.sv
`timescale 1ns/1ps
module dco_tune_seq
  import dco_tune_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   step_i,
  output phase_e phase_o,
  output logic   ld_coarse_o,
  output logic   ld_acq_o,
  output logic   ld_track_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (start_i) phase_d = PH_COARSE;
    else if (step_i) begin
      case (phase_q)
        PH_COARSE: phase_d = PH_ACQ;
        PH_ACQ:    phase_d = PH_TRACK;
        default:   phase_d = phase_q;
      endcase
    end
  end

  assign ld_coarse_o = start_i;
  assign ld_acq_o    = !start_i && step_i && (phase_q == PH_COARSE);
  assign ld_track_o  = !start_i && step_i && (phase_q == PH_ACQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (phase_q == PH_COARSE));
  assert_acq_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ACQ) |-> ($past(phase_q) == PH_COARSE || $past(phase_q) == PH_ACQ));
  assert_track_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TRACK) |-> ($past(phase_q) == PH_ACQ || $past(phase_q) == PH_TRACK));
endmodule

// File: rtl/dco_bank_acc.sv
`timescale 1ns/1ps
module dco_bank_acc #(
  parameter int W    = 8,
  parameter int EW   = 6,
  parameter int MAXV = 255,
  parameter int MIDV = 128
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 upd_i,
  input  logic signed [EW-1:0] err_i,
  output logic [W-1:0]         val_o
);
  localparam int SW = ((W > EW) ? W : EW) + 2;

  logic [W-1:0]         val_q, val_d;
  logic signed [SW-1:0] sum;

  always_comb begin
    sum = $signed({{(SW-W){1'b0}}, val_q}) + SW'(err_i);
    if (sum < 0)                 val_d = '0;
    else if (sum > SW'(MAXV))    val_d = W'(MAXV);
    else                         val_d = sum[W-1:0];
  end

  // reload wins over an update in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= W'(MIDV);
    else if (load_i) val_q <= W'(MIDV);
    else if (upd_i)  val_q <= val_d;
  end

  assign val_o = val_q;

  assert_sat_hi_R6_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !load_i && val_q == W'(MAXV) && !err_i[EW-1]) |=> (val_q == W'(MAXV)));
  assert_sat_lo_R6_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !load_i && val_q == '0 && err_i[EW-1]) |=> (val_q == '0));
endmodule

// File: rtl/dco_thermo.sv
`timescale 1ns/1ps
module dco_thermo #(
  parameter int N  = 64,
  parameter int CW = 7
) (
  input  logic [CW-1:0] cnt_i,
  output logic [N-1:0]  therm_o
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    assign therm_o[i] = (cnt_i > CW'(i));
  end
endmodule

// File: rtl/dco_sd_dither.sv
`timescale 1ns/1ps
module dco_sd_dither #(
  parameter int FW = 5,
  parameter int OW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          en_i,
  input  logic [FW-1:0] frac_i,
  output logic [OW-1:0] dith_o
);
  localparam int LW   = FW - OW;
  localparam int FMAX = ((1 << OW) - 1) << LW;

  logic [FW-1:0] fc;
  logic [LW-1:0] acc_q;
  logic [LW:0]   sum;
  logic [OW-1:0] fc_hi;

  // clip so the top level plus a carry stays within OW bits
  assign fc    = (frac_i > FW'(FMAX)) ? FW'(FMAX) : frac_i;
  assign fc_hi = fc[FW-1:LW];
  assign sum   = {1'b0, acc_q} + {1'b0, fc[LW-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      dith_o <= '0;
    end else if (!act_i) begin
      acc_q  <= '0;
      dith_o <= '0;
    end else if (en_i) begin
      acc_q  <= sum[LW-1:0];
      dith_o <= fc_hi + OW'(sum[LW]);
    end
  end

  assert_dith_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && en_i) |=> ({1'b0, dith_o} == {1'b0, $past(fc_hi)} ||
                         {1'b0, dith_o} == {1'b0, $past(fc_hi)} + 1'b1));
  assert_dith_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> (dith_o == '0));
endmodule

// File: rtl/dco_tune_ctrl.sv
`timescale 1ns/1ps
module dco_tune_ctrl
  import dco_tune_pkg::*;
#(
  parameter int CB    = 8,
  parameter int AB    = 8,
  parameter int NUNIT = 64,
  parameter int EW    = 6,
  parameter int FW    = 5,
  parameter int OW    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 step_i,
  input  logic                 upd_i,
  input  logic signed [EW-1:0] err_i,
  input  logic                 fast_en_i,
  input  logic [FW-1:0]        frac_i,
  output logic [1:0]           phase_o,
  output logic [CB-1:0]        coarse_o,
  output logic [AB-1:0]        acq_o,
  output logic [NUNIT-1:0]     track_o,
  output logic [OW-1:0]        dith_o
);
  localparam int TCW = $clog2(NUNIT + 1);

  phase_e         phase;
  logic           ld_coarse, ld_acq, ld_track;
  logic [TCW-1:0] track_cnt;

  dco_tune_seq u_seq (
    .clk_i, .rst_ni, .start_i, .step_i,
    .phase_o(phase), .ld_coarse_o(ld_coarse), .ld_acq_o(ld_acq), .ld_track_o(ld_track)
  );

  dco_bank_acc #(.W(CB), .EW(EW), .MAXV((1 << CB) - 1), .MIDV(1 << (CB - 1))) u_coarse (
    .clk_i, .rst_ni, .load_i(ld_coarse), .upd_i(upd_i && phase == PH_COARSE),
    .err_i, .val_o(coarse_o)
  );

  dco_bank_acc #(.W(AB), .EW(EW), .MAXV((1 << AB) - 1), .MIDV(1 << (AB - 1))) u_acq (
    .clk_i, .rst_ni, .load_i(ld_acq), .upd_i(upd_i && phase == PH_ACQ),
    .err_i, .val_o(acq_o)
  );

  dco_bank_acc #(.W(TCW), .EW(EW), .MAXV(NUNIT), .MIDV(NUNIT / 2)) u_track (
    .clk_i, .rst_ni, .load_i(ld_track), .upd_i(upd_i && phase == PH_TRACK),
    .err_i, .val_o(track_cnt)
  );

  dco_thermo #(.N(NUNIT), .CW(TCW)) u_thermo (
    .cnt_i(track_cnt), .therm_o(track_o)
  );

  dco_sd_dither #(.FW(FW), .OW(OW)) u_sd (
    .clk_i, .rst_ni, .act_i(phase == PH_TRACK), .en_i(fast_en_i),
    .frac_i, .dith_o
  );

  assign phase_o = phase;

  assert_therm_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(track_o) == int'(track_cnt));
  assert_therm_shape_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((track_o + 1'b1) & track_o) == '0);
  assert_track_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(track_cnt) <= NUNIT);
  assert_coarse_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase) != PH_COARSE && phase != PH_COARSE) |-> $stable(coarse_o));
  assert_acq_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase) != PH_ACQ && phase != PH_ACQ) |-> $stable(acq_o));
endmodule

// File: tb/dco_tune_ctrl_tb_top.sv
`timescale 1ns/1ps
module dco_tune_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, step = 1'b0, upd = 1'b0, fast_en = 1'b0;
  logic signed [5:0] err = '0;
  logic [4:0]  frac = '0;
  logic [1:0]  phase;
  logic [7:0]  coarse, acq;
  logic [63:0] track;
  logic [2:0]  dith;

  int total = 0, bad = 0;
  int m_phase = 0, m_coarse = 128, m_acq = 128, m_cnt = 32, m_acc = 0, m_dith = 0;

  always #10 clk = ~clk;

  dco_tune_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_i(step), .upd_i(upd),
    .err_i(err), .fast_en_i(fast_en), .frac_i(frac), .phase_o(phase),
    .coarse_o(coarse), .acq_o(acq), .track_o(track), .dith_o(dith)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int sat(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [63:0] therm(input int n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic chk_all(input string tag);
    chk(tag, "phase", 64'(phase), 64'(m_phase));
    chk(tag, "coarse", 64'(coarse), 64'(m_coarse));
    chk(tag, "acq", 64'(acq), 64'(m_acq));
    chk(tag, "track", track, therm(m_cnt));
    chk(tag, "dith", 64'(dith), 64'(m_dith));
  endtask

  // one clock: drive, update reference from pre-edge state, check after edge
  task automatic cyc(input bit st, input bit sp, input bit up, input int e,
                     input bit fe, input int fr, input string tag);
    int op, fc, s;
    @(negedge clk);
    start = st; step = sp; upd = up; err = 6'(e); fast_en = fe; frac = 5'(fr);
    @(posedge clk);
    op = m_phase;
    if (op != 3) begin m_acc = 0; m_dith = 0; end
    else if (fe) begin
      fc = (fr > 28) ? 28 : fr;
      s = m_acc + (fc % 4);
      m_dith = fc / 4 + s / 4;
      m_acc = s % 4;
    end
    if (up && op == 1) m_coarse = sat(m_coarse + e, 255);
    if (up && op == 2) m_acq = sat(m_acq + e, 255);
    if (up && op == 3) m_cnt = sat(m_cnt + e, 64);
    if (st) begin m_phase = 1; m_coarse = 128; end
    else if (sp && op == 1) begin m_phase = 2; m_acq = 128; end
    else if (sp && op == 2) begin m_phase = 3; m_cnt = 32; end
    #1;
    chk_all(tag);
  endtask

  task automatic t_reset;
    chk_all("R1");
  endtask

  task automatic t_idle_ignore;
    cyc(0, 1, 1, 9, 1, 13, "R3");   // step in idle ignored
    cyc(0, 0, 1, -20, 0, 0, "R4");  // update in idle changes nothing
    chk("R3", "phase_idle", 64'(phase), 64'd0);
  endtask

  task automatic t_sequence;
    cyc(1, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 1, 5, 0, 0, "R4");
    chk("R4", "coarse_plus5", 64'(coarse), 64'd133);
    cyc(0, 0, 1, -10, 0, 0, "R4");
    chk("R4", "coarse_minus10", 64'(coarse), 64'd123);
    cyc(0, 1, 1, 2, 0, 0, "R3");    // update and step together
    chk("R3", "coarse_last", 64'(coarse), 64'd125);
    cyc(0, 0, 1, 7, 0, 0, "R5");
    chk("R5", "coarse_frozen", 64'(coarse), 64'd125);
    chk("R4", "acq_plus7", 64'(acq), 64'd135);
    cyc(0, 1, 0, 0, 0, 0, "R3");
    chk("R3", "track_mid", track, 64'h0000_0000_FFFF_FFFF);
    cyc(0, 0, 1, 3, 0, 0, "R5");
    chk("R5", "acq_frozen", 64'(acq), 64'd135);
    cyc(0, 1, 0, 0, 0, 0, "R3");    // step in tracking ignored
    chk("R3", "stay_track", 64'(phase), 64'd3);
    cyc(1, 1, 1, 4, 0, 0, "R2");    // start wins over step and update
    chk("R2", "restart", 64'(coarse), 64'd128);
  endtask

  task automatic t_sat_coarse;
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 31, 0, 0, "R6");
    chk("R6", "coarse_top", 64'(coarse), 64'd255);
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, -32, 0, 0, "R6");
    chk("R6", "coarse_bottom", 64'(coarse), 64'd0);
    cyc(0, 1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 31, 0, 0, "R6");
    chk("R6", "acq_top", 64'(acq), 64'd255);
  endtask

  task automatic t_track_sweep;
    cyc(0, 1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, -1, 0, 0, "R8");
    chk("R7", "track_zero", track, 64'd0);
    for (int i = 0; i < 70; i++) cyc(0, 0, 1, 1, 0, 0, "R8");
    chk("R7", "track_full", track, '1);
    cyc(0, 0, 1, 31, 0, 0, "R7");
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, (i % 2) ? 13 : -17, 0, 0, "R8");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, -32, 0, 0, "R7");
    chk("R7", "track_floor", track, 64'd0);
    cyc(0, 0, 1, 5, 0, 0, "R8");
    chk("R8", "track_five", track, 64'h1F);
  endtask

  task automatic t_dither;
    int fr_list[6] = '{0, 5, 13, 28, 31, 22};
    foreach (fr_list[k]) begin
      int sum = 0, fc;
      fc = (fr_list[k] > 28) ? 28 : fr_list[k];
      for (int i = 0; i < 64; i++) begin
        cyc(0, 0, 0, 0, 1, fr_list[k], "R9");
        sum += int'(dith);
      end
      chk("R9", "dith_sum", 64'(sum), 64'(16 * fc));
    end
    cyc(0, 0, 0, 0, 0, 7, "R9");     // no enable: level held
  endtask

  task automatic t_dither_idle;
    cyc(1, 0, 0, 0, 1, 13, "R10");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, 13, "R10");
    chk("R10", "dith_off", 64'(dith), 64'd0);
    cyc(0, 1, 0, 0, 1, 13, "R10");
    cyc(0, 1, 0, 0, 1, 13, "R10");   // enters tracking, still cleared
    chk("R10", "dith_entry", 64'(dith), 64'd0);
    cyc(0, 0, 0, 0, 1, 13, "R10");   // 3 + (0+1)/4 = 3
    chk("R10", "dith_first", 64'(dith), 64'd3);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_idle_ignore();
    t_sequence();
    t_sat_coarse();
    t_track_sweep();
    t_dither();
    t_dither_idle();
    finish_run();
  end
endmodule